// File: doc/BRIEF.md
# Camera PHY Bring-Up Sequencer

This block is a control state machine that takes a camera serial receiver PHY from reset to an active, receiving state. Software starts it with a one-cycle start pulse. It then steps through a fixed order of operations:

1. It releases the PHY reset and waits for the PHY to report that the reset has completed. That report only appears once the sensor at the far end is sending its high-speed byte clock.
2. It requests forced receive mode and waits for the PHY to acknowledge it.
3. It places a weak pull-down on the link.
4. It commands the PHY to power up.
5. It waits until every enabled lane is in stop state and forced receive mode has cleared itself.
6. It lifts the pull-down and reports ready.

The lane-position and camera-mode configuration are captured when the sequence starts and are held steady for as long as it runs. Each step that waits on the PHY has a programmable cycle limit. When a limit expires, the block parks every output in a safe state and reports a fault code that names the stalled step. An abort input, or the global reset, returns all outputs to the safe state at once.

Top module: `cphy_bringup_seq`

## Requirements
- R1: After reset, the outputs hold safe values: phy_rst_ctrl_o=0, force_rx_req_o=0, pulldn_n_o=1, pwr_cmd_o=2'b00, done_o=0, err_o=0, err_code_o=0.
- R2: cfg_pos_o and cfg_mode_o take the values of cfg_pos_i and cfg_mode_i on the cycle a start is accepted. They do not follow those inputs again until the next accepted start.
- R3: In the cycle after an accepted start, phy_rst_ctrl_o is 1 while force_rx_req_o=0, pulldn_n_o=1 and pwr_cmd_o=00. The sequence does not advance until reset_done_i is 1.
- R4: After reset-done, force_rx_req_o is 1 until force_rx_stat_i reads 1. Next, pulldn_n_o drops to 0 (0 means pull-down on). One cycle later, pwr_cmd_o becomes 2'b01.
- R5: The sequence leaves the stop-state wait only when force_rx_stat_i is 0 and every lane whose lane_en_i bit is 1 has its stop_state_i bit at 1. Lanes with a lane_en_i bit of 0 never hold it back.
- R6: pulldn_n_o returns to 1 only after the R5 condition has been met. One cycle later done_o is 1, with pwr_cmd_o=01 and phy_rst_ctrl_o=1.
- R7: A wait step whose condition stays false for tmo_limit_i+1 cycles ends in a fault. err_o becomes 1 and err_code_o shows the step: 1 for reset-done, 2 for the force-receive acknowledge, 3 for stop state.
- R8: In the fault state, the outputs hold the R1 safe values and err_code_o is held. A new start clears the fault and begins the sequence again.
- R9: A start pulse while done_o is 1 has no effect.
- R10: An abort_i pulse returns the block to idle on the next clock edge, with the R1 safe values on every PHY-facing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse from software |
| abort_i | input | 1 | Abort pulse; returns to idle |
| lane_en_i | input | NUM_LANES | Lanes that take part in the stop-state check |
| tmo_limit_i | input | TMO_W | Cycle limit for each wait step |
| cfg_pos_i | input | (NUM_LANES+1)*POS_W | Lane and clock position configuration |
| cfg_mode_i | input | MODE_W | Camera mode configuration |
| reset_done_i | input | 1 | PHY reset-complete status |
| force_rx_stat_i | input | 1 | Forced receive mode status from the PHY |
| stop_state_i | input | NUM_LANES | Per-lane stop-state status |
| phy_rst_ctrl_o | output | 1 | 1 releases the PHY reset |
| force_rx_req_o | output | 1 | Forced receive mode request |
| pulldn_n_o | output | 1 | Link pull-down control, 0 = pull-down on |
| pwr_cmd_o | output | 2 | PHY power command, 01 = power on |
| cfg_pos_o | output | (NUM_LANES+1)*POS_W | Locked position configuration |
| cfg_mode_o | output | MODE_W | Locked camera mode |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | PHY ready |
| err_o | output | 1 | Step timed out |
| err_code_o | output | 2 | Step that timed out |

## Verification
The bench builds the block with four lanes, 3-bit positions, a 2-bit mode and an 8-bit limit. This lets it program short limits of 5 and 20 cycles, so every fault path ends within a few dozen cycles and the R7 boundary can be sampled on the exact cycle. With four lanes, the mask table covers the full mask, partial masks, an empty mask and a single lane. It also covers the cases where stopped lanes sit outside the mask. A small PHY model that can refuse to acknowledge or to clear forced receive mode reaches each of the three fault codes.

// File: rtl/cphy_bringup_pkg.sv
package cphy_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_RSTREL = 4'd1,
    ST_FRXREQ = 4'd2,
    ST_PDON   = 4'd3,
    ST_PWRUP  = 4'd4,
    ST_WSTOP  = 4'd5,
    ST_PDREL  = 4'd6,
    ST_READY  = 4'd7,
    ST_FAULT  = 4'd8
  } seq_state_t;

  typedef enum logic [1:0] {
    CODE_NONE  = 2'd0,
    CODE_RSTDN = 2'd1,
    CODE_FRXAK = 2'd2,
    CODE_STOP  = 2'd3
  } fault_code_t;

  typedef struct packed {
    logic       rst_ctrl;
    logic       frx_req;
    logic       pd_n;
    logic [1:0] pwr;
  } phy_drive_t;

  localparam logic [1:0] PWR_OFF = 2'b00;
  localparam logic [1:0] PWR_ON  = 2'b01;

  // PHY-facing output levels for each step
  function automatic phy_drive_t drive_for(seq_state_t s);
    phy_drive_t d;
    d = '{rst_ctrl: 1'b0, frx_req: 1'b0, pd_n: 1'b1, pwr: PWR_OFF};
    case (s)
      ST_RSTREL: d.rst_ctrl = 1'b1;
      ST_FRXREQ: begin d.rst_ctrl = 1'b1; d.frx_req = 1'b1; end
      ST_PDON:   begin d.rst_ctrl = 1'b1; d.pd_n = 1'b0; end
      ST_PWRUP, ST_WSTOP: begin d.rst_ctrl = 1'b1; d.pd_n = 1'b0; d.pwr = PWR_ON; end
      ST_PDREL, ST_READY: begin d.rst_ctrl = 1'b1; d.pwr = PWR_ON; end
      default: ;
    endcase
    return d;
  endfunction

  // fault code reported when a given wait step stalls
  function automatic fault_code_t code_for(seq_state_t s);
    case (s)
      ST_RSTREL: return CODE_RSTDN;
      ST_FRXREQ: return CODE_FRXAK;
      ST_WSTOP:  return CODE_STOP;
      default:   return CODE_NONE;
    endcase
  endfunction

  function automatic logic is_wait(seq_state_t s);
    return (s == ST_RSTREL) || (s == ST_FRXREQ) || (s == ST_WSTOP);
  endfunction

endpackage

// File: rtl/cphy_lane_ready.sv
module cphy_lane_ready #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0] lane_en_i,
  input  logic [NUM_LANES-1:0] stop_state_i,
  output logic                 all_ready_o
);
  logic [NUM_LANES-1:0] lane_ok;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    // a masked-out lane counts as ready
    assign lane_ok[g] = stop_state_i[g] | ~lane_en_i[g];
  end

  assign all_ready_o = &lane_ok;
endmodule

// File: rtl/cphy_step_timer.sv
module cphy_step_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/cphy_cfg_lock.sv
module cphy_cfg_lock #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cphy_bringup_seq.sv
module cphy_bringup_seq
  import cphy_bringup_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int POS_W     = 3,
  parameter int MODE_W    = 2,
  parameter int TMO_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           abort_i,
  input  logic [NUM_LANES-1:0]           lane_en_i,
  input  logic [TMO_W-1:0]               tmo_limit_i,
  input  logic [(NUM_LANES+1)*POS_W-1:0] cfg_pos_i,
  input  logic [MODE_W-1:0]              cfg_mode_i,
  input  logic                           reset_done_i,
  input  logic                           force_rx_stat_i,
  input  logic [NUM_LANES-1:0]           stop_state_i,
  output logic                           phy_rst_ctrl_o,
  output logic                           force_rx_req_o,
  output logic                           pulldn_n_o,
  output logic [1:0]                     pwr_cmd_o,
  output logic [(NUM_LANES+1)*POS_W-1:0] cfg_pos_o,
  output logic [MODE_W-1:0]              cfg_mode_o,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           err_o,
  output logic [1:0]                     err_code_o
);
  localparam int CFG_W = (NUM_LANES + 1) * POS_W;

  seq_state_t  state_q, state_d;
  fault_code_t code_q;
  phy_drive_t  drv;

  // named internal events
  logic lanes_ready;
  logic wait_met;
  logic tmo_expired;
  logic tmo_hit;
  logic start_acc;
  logic step_change;

  cphy_lane_ready #(.NUM_LANES(NUM_LANES)) u_lanes (
    .lane_en_i   (lane_en_i),
    .stop_state_i(stop_state_i),
    .all_ready_o (lanes_ready)
  );

  assign wait_met    = lanes_ready & ~force_rx_stat_i;
  assign start_acc   = start_i & ~abort_i & ((state_q == ST_IDLE) | (state_q == ST_FAULT));
  assign step_change = (state_d != state_q);
  assign tmo_hit     = tmo_expired & is_wait(state_q);

  cphy_step_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (step_change),
    .limit_i  (tmo_limit_i),
    .expired_o(tmo_expired)
  );

  cphy_cfg_lock #(.W(CFG_W)) u_lock_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(start_acc),
    .d_i   (cfg_pos_i),
    .q_o   (cfg_pos_o)
  );

  cphy_cfg_lock #(.W(MODE_W)) u_lock_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(start_acc),
    .d_i   (cfg_mode_i),
    .q_o   (cfg_mode_o)
  );

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_FAULT: if (start_i) state_d = ST_RSTREL;
        ST_RSTREL: begin
          if (reset_done_i) state_d = ST_FRXREQ;
          else if (tmo_hit) state_d = ST_FAULT;
        end
        ST_FRXREQ: begin
          if (force_rx_stat_i) state_d = ST_PDON;
          else if (tmo_hit)    state_d = ST_FAULT;
        end
        ST_PDON:  state_d = ST_PWRUP;
        ST_PWRUP: state_d = ST_WSTOP;
        ST_WSTOP: begin
          if (wait_met)     state_d = ST_PDREL;
          else if (tmo_hit) state_d = ST_FAULT;
        end
        ST_PDREL: state_d = ST_READY;
        ST_READY: state_d = ST_READY;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_NONE;
    end else begin
      state_q <= state_d;
      if (abort_i || start_acc)       code_q <= CODE_NONE;
      else if (state_d == ST_FAULT && state_q != ST_FAULT) code_q <= code_for(state_q);
    end
  end

  assign drv            = drive_for(state_q);
  assign phy_rst_ctrl_o = drv.rst_ctrl;
  assign force_rx_req_o = drv.frx_req;
  assign pulldn_n_o     = drv.pd_n;
  assign pwr_cmd_o      = drv.pwr;
  assign busy_o         = (state_q != ST_IDLE) && (state_q != ST_READY) && (state_q != ST_FAULT);
  assign done_o         = (state_q == ST_READY);
  assign err_o          = (state_q == ST_FAULT);
  assign err_code_o     = code_q;

  // ---------------- assertions ----------------
  assert_safe_after_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_i) |-> (!phy_rst_ctrl_o && !force_rx_req_o && pulldn_n_o && pwr_cmd_o == PWR_OFF));

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(cfg_pos_o) && $stable(cfg_mode_o)));

  assert_pd_on_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulldn_n_o) |-> (phy_rst_ctrl_o && $past(force_rx_stat_i)));

  assert_pd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulldn_n_o) |-> ($past(abort_i) || err_o || $past(wait_met)));

  assert_done_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pulldn_n_o && phy_rst_ctrl_o && pwr_cmd_o == PWR_ON));

  assert_fault_from_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(tmo_hit));

  assert_fault_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!phy_rst_ctrl_o && pulldn_n_o && pwr_cmd_o == PWR_OFF && err_code_o != 2'd0));

  assert_pwr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cmd_o == PWR_OFF) || (pwr_cmd_o == PWR_ON));
endmodule

// File: tb/cphy_bringup_seq_tb.sv
module cphy_bringup_seq_tb;
  localparam int NL = 4;
  localparam int PW = 3;
  localparam int MW = 2;
  localparam int TW = 8;
  localparam int CW = (NL + 1) * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0;
  logic [NL-1:0] lane_en_i = '1, stop_state_i = '1;
  logic [TW-1:0] tmo_limit_i = 8'd20;
  logic [CW-1:0] cfg_pos_i = '0;
  logic [MW-1:0] cfg_mode_i = '0;
  logic reset_done_i = 1'b1, force_rx_stat_i = 1'b0;
  logic phy_rst_ctrl_o, force_rx_req_o, pulldn_n_o, busy_o, done_o, err_o;
  logic [1:0] pwr_cmd_o, err_code_o;
  logic [CW-1:0] cfg_pos_o;
  logic [MW-1:0] cfg_mode_o;

  logic phy_acks = 1'b1, phy_clears = 1'b1;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cphy_bringup_seq #(.NUM_LANES(NL), .POS_W(PW), .MODE_W(MW), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .lane_en_i(lane_en_i), .tmo_limit_i(tmo_limit_i), .cfg_pos_i(cfg_pos_i),
    .cfg_mode_i(cfg_mode_i), .reset_done_i(reset_done_i),
    .force_rx_stat_i(force_rx_stat_i), .stop_state_i(stop_state_i),
    .phy_rst_ctrl_o(phy_rst_ctrl_o), .force_rx_req_o(force_rx_req_o),
    .pulldn_n_o(pulldn_n_o), .pwr_cmd_o(pwr_cmd_o), .cfg_pos_o(cfg_pos_o),
    .cfg_mode_o(cfg_mode_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_code_o(err_code_o)
  );

  // simple PHY model: forced receive mode latched on request, self-clears after
  initial begin
    forever begin
      @(posedge clk);
      if (phy_acks && force_rx_req_o)        force_rx_stat_i <= 1'b1;
      else if (phy_clears && !force_rx_req_o) force_rx_stat_i <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {rst_ctrl, force_req, pd_n, pwr}
  function automatic logic [4:0] phy_outs();
    return {phy_rst_ctrl_o, force_rx_req_o, pulldn_n_o, pwr_cmd_o};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
  endtask

  typedef struct packed {
    logic [NL-1:0] en;
    logic [NL-1:0] stop;
    logic          ok;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{en: 4'hF, stop: 4'hF, ok: 1'b1},
    '{en: 4'hF, stop: 4'h7, ok: 1'b0},
    '{en: 4'h3, stop: 4'h3, ok: 1'b1},
    '{en: 4'h3, stop: 4'hC, ok: 1'b0},
    '{en: 4'h0, stop: 4'h0, ok: 1'b1},
    '{en: 4'h8, stop: 4'h8, ok: 1'b1},
    '{en: 4'h5, stop: 4'hA, ok: 1'b0},
    '{en: 4'hA, stop: 4'hE, ok: 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: safe values out of reset
    check("R1 phy outs", phy_outs(), 5'b00100);
    check("R1 status", {done_o, err_o, err_code_o}, 4'b0000);
    rst_n = 1'b1;

    // R5: lane-mask table
    for (int i = 0; i < 8; i++) begin
      pulse_abort();
      lane_en_i = VEC[i].en;
      stop_state_i = VEC[i].stop;
      pulse_start();
      repeat (40) @(negedge clk);
      check("R5 done", done_o, VEC[i].ok);
      check("R7 code 3", err_code_o, VEC[i].ok ? 2'd0 : 2'd3);
    end

    // R3/R7: reset-done never arrives, limit 5
    pulse_abort();
    lane_en_i = '1; stop_state_i = '1;
    tmo_limit_i = 8'd5; reset_done_i = 1'b0;
    pulse_start();
    check("R3 reset released only", phy_outs(), 5'b10100);
    repeat (5) @(negedge clk);
    check("R7 no fault before limit+1", err_o, 1'b0);
    check("R3 still waiting", phy_outs(), 5'b10100);
    @(negedge clk);
    check("R7 fault at limit+1", {err_o, err_code_o}, 3'b101);
    check("R8 fault safe outs", phy_outs(), 5'b00100);

    // R8: restart from fault succeeds
    reset_done_i = 1'b1; tmo_limit_i = 8'd20;
    pulse_start();
    check("R8 fault cleared on start", {err_o, err_code_o}, 3'b000);
    repeat (20) @(negedge clk);
    check("R8 restart reaches ready", done_o, 1'b1);
    check("R6 ready levels", phy_outs(), 5'b10101);

    // R9: start while ready ignored
    pulse_start();
    repeat (3) @(negedge clk);
    check("R9 start ignored", {done_o, busy_o, phy_outs()}, 7'b1010101);

    // R7 code 2: PHY never acknowledges forced receive
    pulse_abort();
    phy_acks = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    check("R7 code 2", {err_o, err_code_o}, 3'b110);
    phy_acks = 1'b1;

    // R4/R5: forced receive never clears, observe mid-wait then fault
    pulse_abort();
    phy_clears = 1'b0;
    pulse_start();
    repeat (10) @(negedge clk);
    check("R4 pull-down on, power 01 in stop wait", phy_outs(), 5'b10001);
    check("R6 not done while forced rx set", done_o, 1'b0);
    repeat (30) @(negedge clk);
    check("R5 stuck force rx faults code 3", {err_o, err_code_o}, 3'b111);
    phy_clears = 1'b1;
    @(negedge clk); @(negedge clk);

    // R2: config latched at start, later input changes ignored
    pulse_abort();
    cfg_pos_i = 15'h4A53; cfg_mode_i = 2'b10;
    pulse_start();
    cfg_pos_i = 15'h1234; cfg_mode_i = 2'b01;
    repeat (4) @(negedge clk);
    check("R2 pos locked", cfg_pos_o, 15'h4A53);
    check("R2 mode locked", cfg_mode_o, 2'b10);

    // R10: abort mid-sequence
    stop_state_i = 4'h0;
    pulse_abort();
    pulse_start();
    repeat (8) @(negedge clk);
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    check("R10 safe after abort", phy_outs(), 5'b00100);
    check("R10 idle after abort", {busy_o, done_o, err_o}, 3'b000);
    check("R2 lock reloaded on start", cfg_pos_o, 15'h1234);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule